// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is the byte-level command engine of a serial NOR flash target. A link layer outside it turns the serial pins into whole bytes. It signals the start of each chip-select frame with `frame_start` and passes every received byte with `rx_valid`. In the same cycle the sequencer presents one response byte on `tx_byte`. The first byte of a frame is taken as an opcode. The engine then gathers any address, dummy or parameter bytes that the opcode needs. After that it streams array data out, or issues program requests for incoming bytes, or sends a short fixed reply, or issues an erase request.

The engine holds three pieces of state across frames: a write-enable latch, a reset-arm latch and an 8-bit bank register. The two low bits of the bank register choose a 16 MiB window above the 24-bit address carried in a command. Array reads are combinational through `mem_rd_addr`/`mem_rd_data`. Program and erase work is handed to a separate array controller as single-cycle request pulses that appear one cycle after the byte that caused them. Serial shifting, multi-lane pin handling and array timing belong to other blocks.

Top module: `spi_nor_cmd_seq`

## Requirements
- R1: After opcode 0x03 (read), 0x02/0xA2/0x32 (program at x1/x2/x4 width) or 0x20/0x52/0xD8 (erase), the engine collects exactly 3 bytes. After 0x0B (fast read), 0x3B and 0x6B (dual- and quad-output read) it collects exactly 4. The byte after the last collected one is the first data byte.
- R2: Opcode 0xBB (dual I/O read) collects 4 bytes and 0xEB (quad I/O read) collects 6 when the top byte of `JEDEC_ID` is 0xEF or 0x01. Otherwise they collect 5 and 8.
- R3: The command address is the first three collected bytes, most significant first, plus (bank register bits [1:0]) × 0x1000000. It is 26 bits wide.
- R4: In the streaming read state, each received byte returns the array byte at the current address on `tx_byte`. The address then advances by one modulo 2^`SIZE_LOG2`.
- R5: In the program state, each received byte produces one `prog_valid` pulse in the next cycle, carrying the byte and the current address. The address advances by one per byte and wraps at 2^26.
- R6: Opcode 0x05 replies with one byte that holds the write-enable latch in bit 1 and 0 in all other bits.
- R7: Opcode 0x9F replies with the three `JEDEC_ID` bytes, high byte first. When `EXT_ID` is nonzero, the two `EXT_ID` bytes follow, high first. After the last reply byte the next byte is decoded as an opcode.
- R8: Opcodes 0x01 (status write) and 0xC5 (bank write) collect one byte only when write enable is set, and are ignored otherwise. A completed 0xC5 loads the byte into the bank register. A completed 0x01 clears write enable. Opcode 0xC8 replies with the bank register.
- R9: A completed erase opcode pulses `erase_valid` with the R3 address, but only when write enable is set. `erase_kind` is 0 for 0x20, 1 for 0x52 and 2 for 0xD8. Opcode 0xC7 pulses `erase_valid` at once with kind 3 and address 0, again only when write enable is set.
- R10: Any opcode other than 0x99 clears the reset-arm latch, and 0x66 then sets it. Opcode 0x99 with the latch set clears write enable, the bank register, the current address and the latch. Without the latch set, 0x99 does nothing.
- R11: `frame_start` clears the collection counters and returns the engine to idle, so the next byte is decoded as an opcode.
- R12: `tx_byte` is 0 in idle, collect and program states. Unknown opcodes and 0x00 change nothing, and the next byte is decoded as an opcode.
- R13: Opcode 0x06 sets write enable and 0x04 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse at chip-select assertion |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Response byte for the byte in this cycle |
| mem_rd_addr | output | 26 | Array read address (current address) |
| mem_rd_data | input | 8 | Array byte at `mem_rd_addr` |
| prog_valid | output | 1 | Program request pulse |
| prog_addr | output | 26 | Program address |
| prog_data | output | 8 | Program data byte |
| erase_valid | output | 1 | Erase request pulse |
| erase_kind | output | 2 | 0 = 4 KiB, 1 = 32 KiB, 2 = sector, 3 = whole array |
| erase_addr | output | 26 | Erase address |

## Verification
The bench counts trailing bytes for every read opcode, including the vendor-dependent dual and quad I/O forms. A wrong count shifts every streamed byte by one position or more. It reads across the end of the array, where a missing wrap would return data from beyond the device size. It also programs in bank 3 near the top of the 26-bit space, where a dropped bank term shows up as a wrong `prog_addr`. Gated commands are issued with write enable both clear and set, so an erase, a bank write or a status write that ignored the latch shows up as a stray pulse or a changed bank read-back. The reset-arm tests put an unrelated opcode between arm and reset, and they break a frame in the middle of collecting and in the middle of streaming.

// File: rtl/snc_pkg.sv
`timescale 1ns/1ps
package snc_pkg;

  localparam int unsigned BASE_AW   = 24;
  localparam int unsigned BANK_W    = 2;
  localparam int unsigned FULL_AW   = BASE_AW + BANK_W;
  localparam int unsigned REPLY_MAX = 5;
  localparam int unsigned NEED_W    = 4;

  localparam logic [7:0] OP_NOP        = 8'h00;
  localparam logic [7:0] OP_STAT_WR    = 8'h01;
  localparam logic [7:0] OP_PROG       = 8'h02;
  localparam logic [7:0] OP_RD         = 8'h03;
  localparam logic [7:0] OP_WR_DIS     = 8'h04;
  localparam logic [7:0] OP_STAT_RD    = 8'h05;
  localparam logic [7:0] OP_WR_EN      = 8'h06;
  localparam logic [7:0] OP_RD_FAST    = 8'h0B;
  localparam logic [7:0] OP_ERASE_4K   = 8'h20;
  localparam logic [7:0] OP_PROG_X4    = 8'h32;
  localparam logic [7:0] OP_RD_X2OUT   = 8'h3B;
  localparam logic [7:0] OP_ERASE_32K  = 8'h52;
  localparam logic [7:0] OP_ARM_RST    = 8'h66;
  localparam logic [7:0] OP_RD_X4OUT   = 8'h6B;
  localparam logic [7:0] OP_DO_RST     = 8'h99;
  localparam logic [7:0] OP_ID_RD      = 8'h9F;
  localparam logic [7:0] OP_PROG_X2    = 8'hA2;
  localparam logic [7:0] OP_RD_X2IO    = 8'hBB;
  localparam logic [7:0] OP_BANK_WR    = 8'hC5;
  localparam logic [7:0] OP_CHIP_ERASE = 8'hC7;
  localparam logic [7:0] OP_BANK_RD    = 8'hC8;
  localparam logic [7:0] OP_ERASE_SECT = 8'hD8;
  localparam logic [7:0] OP_RD_X4IO    = 8'hEB;

  typedef enum logic [2:0] {
    ST_IDLE, ST_COLLECT, ST_STREAM, ST_PROGRAM, ST_REPLY
  } seq_state_e;

  typedef enum logic [1:0] {
    ER_4K = 2'd0, ER_32K = 2'd1, ER_SECT = 2'd2, ER_CHIP = 2'd3
  } erase_kind_e;

  typedef enum logic [1:0] {
    RSRC_STATUS, RSRC_ID, RSRC_BANK
  } reply_src_e;

  // Actions taken on an opcode byte seen in idle.
  typedef struct packed {
    logic              collect;
    logic [NEED_W-1:0] need;
    logic              wel_set;
    logic              wel_clr;
    logic              reply;
    reply_src_e        src;
    logic              chip_erase;
    logic              arm;
    logic              soft_rst;
  } op_dec_t;

  // Actions taken when the last trailing byte arrives.
  typedef struct packed {
    logic        to_stream;
    logic        to_program;
    logic        erase;
    erase_kind_e kind;
    logic        wel_clr;
    logic        bank_load;
  } fin_dec_t;

endpackage

// File: rtl/snc_decode.sv
`timescale 1ns/1ps
module snc_decode
  import snc_pkg::*;
#(
  parameter bit WIDE_VENDOR = 1'b0
) (
  input  logic [7:0] opc,
  input  logic       wel,
  input  logic       rst_armed,
  input  logic [7:0] cmd,
  output op_dec_t    dec,
  output fin_dec_t   fin
);

  // Trailing byte counts of the I/O-mode reads depend on the ID vendor byte.
  localparam logic [NEED_W-1:0] NEED_X2IO = WIDE_VENDOR ? NEED_W'(4) : NEED_W'(5);
  localparam logic [NEED_W-1:0] NEED_X4IO = WIDE_VENDOR ? NEED_W'(6) : NEED_W'(8);

  always_comb begin
    dec = '0;
    dec.src = RSRC_STATUS;
    unique case (opc)
      OP_RD, OP_PROG, OP_PROG_X2, OP_PROG_X4,
      OP_ERASE_4K, OP_ERASE_32K, OP_ERASE_SECT: begin
        dec.collect = 1'b1;
        dec.need    = NEED_W'(3);
      end
      OP_RD_FAST, OP_RD_X2OUT, OP_RD_X4OUT: begin
        dec.collect = 1'b1;
        dec.need    = NEED_W'(4);
      end
      OP_RD_X2IO: begin
        dec.collect = 1'b1;
        dec.need    = NEED_X2IO;
      end
      OP_RD_X4IO: begin
        dec.collect = 1'b1;
        dec.need    = NEED_X4IO;
      end
      OP_STAT_WR, OP_BANK_WR: begin
        dec.collect = wel;
        dec.need    = NEED_W'(1);
      end
      OP_WR_DIS:     dec.wel_clr = 1'b1;
      OP_WR_EN:      dec.wel_set = 1'b1;
      OP_STAT_RD: begin
        dec.reply = 1'b1;
        dec.src   = RSRC_STATUS;
      end
      OP_ID_RD: begin
        dec.reply = 1'b1;
        dec.src   = RSRC_ID;
      end
      OP_BANK_RD: begin
        dec.reply = 1'b1;
        dec.src   = RSRC_BANK;
      end
      OP_CHIP_ERASE: dec.chip_erase = wel;
      OP_ARM_RST:    dec.arm        = 1'b1;
      OP_DO_RST:     dec.soft_rst   = rst_armed;
      default:       dec = dec;
    endcase
  end

  always_comb begin
    fin = '0;
    fin.kind = ER_4K;
    unique case (cmd)
      OP_PROG, OP_PROG_X2, OP_PROG_X4: fin.to_program = 1'b1;
      OP_RD, OP_RD_FAST, OP_RD_X2OUT, OP_RD_X4OUT,
      OP_RD_X2IO, OP_RD_X4IO:          fin.to_stream = 1'b1;
      OP_ERASE_4K: begin
        fin.erase = 1'b1;
        fin.kind  = ER_4K;
      end
      OP_ERASE_32K: begin
        fin.erase = 1'b1;
        fin.kind  = ER_32K;
      end
      OP_ERASE_SECT: begin
        fin.erase = 1'b1;
        fin.kind  = ER_SECT;
      end
      OP_STAT_WR: fin.wel_clr   = 1'b1;
      OP_BANK_WR: fin.bank_load = 1'b1;
      default:    fin = fin;
    endcase
  end

endmodule

// File: rtl/snc_collect.sv
`timescale 1ns/1ps
module snc_collect
  import snc_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              start,
  input  logic [NEED_W-1:0] need_in,
  input  logic              take,
  input  logic [7:0]        byte_in,
  output logic              done,
  output logic [7:0]        abyte [ADDR_BYTES]
);

  logic [NEED_W-1:0] cnt_q, need_q;
  logic [7:0]        cap_q [ADDR_BYTES];

  assign done = take && ((cnt_q + NEED_W'(1)) == need_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      need_q <= '0;
    end else if (clear) begin
      cnt_q  <= '0;
      need_q <= '0;
    end else if (start) begin
      cnt_q  <= '0;
      need_q <= need_in;
    end else if (take) begin
      cnt_q  <= cnt_q + NEED_W'(1);
    end
  end

  // One capture register per address byte; the byte arriving now is
  // forwarded so the address is complete in the cycle of the last byte.
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_cap
    logic hit;
    assign hit = take && (cnt_q == NEED_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cap_q[g] <= '0;
      else if (hit) cap_q[g] <= byte_in;
    end
    assign abyte[g] = hit ? byte_in : cap_q[g];
  end

  assert_collect_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0 && need_q == '0));

endmodule

// File: rtl/snc_reply.sv
`timescale 1ns/1ps
module snc_reply #(
  parameter int unsigned MAXB = 5,
  localparam int unsigned CW  = $clog2(MAXB + 1),
  localparam int unsigned DEP = 1 << CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            load,
  input  logic [CW-1:0]   load_len,
  input  logic [MAXB*8-1:0] load_data,
  input  logic            adv,
  output logic [7:0]      byte_out,
  output logic            last
);

  logic [CW-1:0] pos_q, len_q;
  logic [7:0]    buf_q [DEP];

  assign last     = (pos_q + CW'(1)) == len_q;
  assign byte_out = buf_q[pos_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      len_q <= '0;
    end else if (clear) begin
      pos_q <= '0;
      len_q <= '0;
    end else if (load) begin
      pos_q <= '0;
      len_q <= load_len;
    end else if (adv) begin
      if (last) begin
        pos_q <= '0;
        len_q <= '0;
      end else begin
        pos_q <= pos_q + CW'(1);
      end
    end
  end

  for (genvar g = 0; g < DEP; g++) begin : g_buf
    if (g < MAXB) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     buf_q[g] <= '0;
        else if (load)  buf_q[g] <= load_data[8*g +: 8];
      end
    end else begin : g_pad
      assign buf_q[g] = '0;
    end
  end

  assert_reply_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) |-> (pos_q < len_q));

endmodule

// File: rtl/spi_nor_cmd_seq.sv
`timescale 1ns/1ps
module spi_nor_cmd_seq
  import snc_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 25,
  parameter logic [23:0] JEDEC_ID  = 24'h20BA19,
  parameter logic [15:0] EXT_ID    = 16'h10A5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  output logic [7:0]         tx_byte,
  output logic [FULL_AW-1:0] mem_rd_addr,
  input  logic [7:0]         mem_rd_data,
  output logic               prog_valid,
  output logic [FULL_AW-1:0] prog_addr,
  output logic [7:0]         prog_data,
  output logic               erase_valid,
  output logic [1:0]         erase_kind,
  output logic [FULL_AW-1:0] erase_addr
);

  localparam int unsigned AW  = FULL_AW;
  localparam int unsigned RCW = $clog2(REPLY_MAX + 1);
  localparam logic [AW-1:0] SIZE_MASK = AW'((64'd1 << SIZE_LOG2) - 64'd1);
  localparam bit WIDE = (JEDEC_ID[23:16] == 8'hEF) || (JEDEC_ID[23:16] == 8'h01);
  localparam int unsigned ID_LEN = (EXT_ID != 16'h0) ? 5 : 3;
  localparam logic [REPLY_MAX*8-1:0] ID_BYTES =
    {EXT_ID[7:0], EXT_ID[15:8], JEDEC_ID[7:0], JEDEC_ID[15:8], JEDEC_ID[23:16]};

  seq_state_e  st_q, st_d;
  logic [7:0]  cmd_q, cmd_d, ear_q, ear_d;
  logic        wel_q, wel_d, arm_q, arm_d;
  logic [AW-1:0] addr_q, addr_d;
  logic        pv_q, pv_d, ev_q, ev_d;
  logic [AW-1:0] pa_q, pa_d, ea_q, ea_d;
  logic [7:0]  pd_q, pd_d;
  erase_kind_e ek_q, ek_d;

  op_dec_t  dec;
  fin_dec_t fin;
  logic     coll_start, coll_take, coll_done, soft_clr;
  logic [7:0] abyte [3];
  logic     rep_load, rep_adv, rep_last;
  logic [RCW-1:0] rep_len;
  logic [REPLY_MAX*8-1:0] rep_data;
  logic [7:0] rep_byte;
  logic [AW-1:0] cmd_addr;

  snc_decode #(.WIDE_VENDOR(WIDE)) u_dec (
    .opc(rx_byte), .wel(wel_q), .rst_armed(arm_q), .cmd(cmd_q),
    .dec(dec), .fin(fin)
  );

  snc_collect #(.ADDR_BYTES(3)) u_col (
    .clk(clk), .rst_n(rst_n), .clear(frame_start | soft_clr),
    .start(coll_start), .need_in(dec.need), .take(coll_take),
    .byte_in(rx_byte), .done(coll_done), .abyte(abyte)
  );

  snc_reply #(.MAXB(REPLY_MAX)) u_rep (
    .clk(clk), .rst_n(rst_n), .clear(frame_start | soft_clr),
    .load(rep_load), .load_len(rep_len), .load_data(rep_data),
    .adv(rep_adv), .byte_out(rep_byte), .last(rep_last)
  );

  assign cmd_addr = AW'({abyte[0], abyte[1], abyte[2]})
                  + {ear_q[BANK_W-1:0], BASE_AW'(0)};

  always_comb begin
    st_d = st_q;  cmd_d = cmd_q;  wel_d = wel_q;  arm_d = arm_q;
    ear_d = ear_q;  addr_d = addr_q;
    pv_d = 1'b0;  pa_d = pa_q;  pd_d = pd_q;
    ev_d = 1'b0;  ek_d = ek_q;  ea_d = ea_q;
    coll_start = 1'b0;  coll_take = 1'b0;  soft_clr = 1'b0;
    rep_load = 1'b0;  rep_adv = 1'b0;  rep_len = '0;  rep_data = '0;
    if (frame_start) begin
      st_d = ST_IDLE;
    end else if (rx_valid) begin
      unique case (st_q)
        ST_IDLE: begin
          cmd_d = rx_byte;
          if (rx_byte != OP_DO_RST) arm_d = 1'b0;
          if (dec.arm)     arm_d = 1'b1;
          if (dec.wel_set) wel_d = 1'b1;
          if (dec.wel_clr) wel_d = 1'b0;
          if (dec.collect) begin
            coll_start = 1'b1;
            st_d = ST_COLLECT;
          end
          if (dec.reply) begin
            rep_load = 1'b1;
            st_d = ST_REPLY;
            unique case (dec.src)
              RSRC_STATUS: begin
                rep_len = RCW'(1);
                rep_data[7:0] = {6'b0, wel_q, 1'b0};
              end
              RSRC_BANK: begin
                rep_len = RCW'(1);
                rep_data[7:0] = ear_q;
              end
              default: begin
                rep_len = RCW'(ID_LEN);
                rep_data = ID_BYTES;
              end
            endcase
          end
          if (dec.chip_erase) begin
            ev_d = 1'b1;
            ek_d = ER_CHIP;
            ea_d = '0;
          end
          if (dec.soft_rst) begin
            cmd_d = OP_NOP;  addr_d = '0;  ear_d = '0;
            wel_d = 1'b0;  arm_d = 1'b0;  st_d = ST_IDLE;
            soft_clr = 1'b1;
          end
        end
        ST_COLLECT: begin
          coll_take = 1'b1;
          if (coll_done) begin
            addr_d = cmd_addr;
            st_d = ST_IDLE;
            if (fin.to_stream)  st_d = ST_STREAM;
            if (fin.to_program) st_d = ST_PROGRAM;
            if (fin.erase && wel_q) begin
              ev_d = 1'b1;
              ek_d = fin.kind;
              ea_d = cmd_addr;
            end
            if (fin.wel_clr)   wel_d = 1'b0;
            if (fin.bank_load) ear_d = abyte[0];
          end
        end
        ST_STREAM:  addr_d = (addr_q + AW'(1)) & SIZE_MASK;
        ST_PROGRAM: begin
          pv_d = 1'b1;
          pa_d = addr_q;
          pd_d = rx_byte;
          addr_d = addr_q + AW'(1);
        end
        ST_REPLY: begin
          rep_adv = 1'b1;
          if (rep_last) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cmd_q <= OP_NOP;  wel_q <= 1'b0;  arm_q <= 1'b0;
      ear_q <= '0;  addr_q <= '0;
      pv_q <= 1'b0;  pa_q <= '0;  pd_q <= '0;
      ev_q <= 1'b0;  ek_q <= ER_4K;  ea_q <= '0;
    end else begin
      st_q <= st_d;  cmd_q <= cmd_d;  wel_q <= wel_d;  arm_q <= arm_d;
      ear_q <= ear_d;  addr_q <= addr_d;
      pv_q <= pv_d;  ev_q <= ev_d;
      if (pv_d) begin
        pa_q <= pa_d;
        pd_q <= pd_d;
      end
      if (ev_d) begin
        ek_q <= ek_d;
        ea_q <= ea_d;
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_STREAM: tx_byte = mem_rd_data;
      ST_REPLY:  tx_byte = rep_byte;
      default:   tx_byte = 8'h00;
    endcase
  end

  assign mem_rd_addr = addr_q;
  assign prog_valid  = pv_q;
  assign prog_addr   = pa_q;
  assign prog_data   = pd_q;
  assign erase_valid = ev_q;
  assign erase_kind  = ek_q;
  assign erase_addr  = ea_q;

  assert_erase_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_valid |-> $past(wel_q));

  assert_frame_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (st_q == ST_IDLE));

  assert_stream_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STREAM && rx_valid && !frame_start)
      |=> (mem_rd_addr == (($past(mem_rd_addr) + AW'(1)) & SIZE_MASK)));

  assert_req_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_valid, erase_valid}));

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && rx_valid && !frame_start && rx_byte == OP_DO_RST && arm_q)
      |=> (!wel_q && ear_q == 8'h00 && mem_rd_addr == '0));

endmodule

// File: tb/tb_spi_nor_cmd_seq.sv
`timescale 1ns/1ps
module tb_spi_nor_cmd_seq;

  logic        clk, rst_n, frame_start, rx_valid;
  logic [7:0]  rx_byte, tx_byte, mem_rd_data, prog_data;
  logic [25:0] mem_rd_addr, prog_addr, erase_addr;
  logic        prog_valid, erase_valid;
  logic [1:0]  erase_kind;

  integer total = 0;
  integer bad   = 0;
  logic [7:0] m_ear;
  logic       m_wel;
  logic        c_pv, c_ev;
  logic [25:0] c_pa, c_ea;
  logic [7:0]  c_pd;
  logic [1:0]  c_ek;
  logic [7:0]  r;

  spi_nor_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_byte(tx_byte), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .prog_valid(prog_valid), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_valid(erase_valid), .erase_kind(erase_kind),
    .erase_addr(erase_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] memf(input logic [25:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ a[23:16] ^ {a[25:24], 6'h2A};
  endfunction

  assign mem_rd_data = memf(mem_rd_addr);

  function automatic int need_of(input logic [7:0] op);
    case (op)
      8'h03: return 3;
      8'h0B, 8'h3B, 8'h6B: return 4;
      8'hBB: return 5;
      8'hEB: return 8;
      default: return 3;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(posedge clk);
    #1 frame_start = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] rsp);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    #1 rsp = tx_byte;
    @(posedge clk);
    #1;
    c_pv = prog_valid; c_pa = prog_addr; c_pd = prog_data;
    c_ev = erase_valid; c_ek = erase_kind; c_ea = erase_addr;
    rx_valid = 1'b0;
  endtask

  task automatic read_status(input string req, input logic exp_wel);
    logic [7:0] q;
    frame(); xfer(8'h05, q); xfer(8'h00, q);
    chk(req, q, {6'b0, exp_wel, 1'b0});
  endtask

  task automatic read_bank(input string req, input logic [7:0] exp);
    logic [7:0] q;
    frame(); xfer(8'hC8, q); xfer(8'h00, q);
    chk(req, q, exp);
  endtask

  task automatic set_bank(input logic [7:0] v);
    logic [7:0] q;
    frame(); xfer(8'h06, q); xfer(8'hC5, q); xfer(v, q);
    m_ear = v; m_wel = 1'b1;
  endtask

  task automatic do_read(input string req, input logic [7:0] op,
                         input logic [23:0] a, input int n);
    logic [7:0] q;
    logic [25:0] cur;
    int nd;
    nd = need_of(op);
    frame();
    xfer(op, q);
    chk({req, " R12 opcode byte"}, q, 8'h00);
    for (int i = 0; i < nd; i++) begin
      if (i < 3) xfer(a[23-8*i -: 8], q);
      else       xfer(8'($urandom), q);
    end
    chk({req, " R12 last collected byte"}, q, 8'h00);
    cur = ({m_ear[1:0], 24'h0} + {2'b0, a}) & 26'h1FFFFFF;
    for (int k = 0; k < n; k++) begin
      xfer(8'($urandom), q);
      chk({req, " R4 stream byte"}, q, memf(cur));
      cur = (cur + 26'd1) & 26'h1FFFFFF;
    end
  endtask

  task automatic do_prog(input string req, input logic [23:0] a, input int n);
    logic [7:0] q, d;
    logic [25:0] cur;
    frame();
    xfer(8'h02, q);
    for (int i = 0; i < 3; i++) xfer(a[23-8*i -: 8], q);
    chk({req, " R5 no request during address"}, {31'b0, c_pv}, 32'd0);
    cur = {m_ear[1:0], 24'h0} + {2'b0, a};
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      xfer(d, q);
      chk({req, " R12 tx in program"}, q, 8'h00);
      chk({req, " R5 prog_valid"}, {31'b0, c_pv}, 32'd1);
      chk({req, " R3 R5 prog_addr"}, c_pa, cur);
      chk({req, " R5 prog_data"}, c_pd, d);
      cur = cur + 26'd1;
    end
  endtask

  task automatic do_erase(input string req, input logic [7:0] op, input logic [23:0] a,
                          input logic en, input logic [1:0] kind);
    logic [7:0] q;
    frame();
    xfer(op, q);
    for (int i = 0; i < 3; i++) xfer(a[23-8*i -: 8], q);
    chk({req, " R9 erase_valid"}, {31'b0, c_ev}, {31'b0, en});
    if (en) begin
      chk({req, " R9 erase_kind"}, c_ek, kind);
      chk({req, " R3 R9 erase_addr"}, c_ea, {m_ear[1:0], 24'h0} + {2'b0, a});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    logic [7:0] ops [6];
    int seed;
    ops[0] = 8'h03; ops[1] = 8'h0B; ops[2] = 8'h3B;
    ops[3] = 8'h6B; ops[4] = 8'hBB; ops[5] = 8'hEB;
    seed = $urandom(32'd1234);
    rst_n = 1'b0; frame_start = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00;
    m_ear = 8'h00; m_wel = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset tx", tx_byte, 8'h00);
    chk("R5 reset prog_valid", {31'b0, prog_valid}, 32'd0);
    chk("R9 reset erase_valid", {31'b0, erase_valid}, 32'd0);
    rst_n = 1'b1;

    read_status("R6 after reset", 1'b0);
    frame(); xfer(8'h06, q); xfer(8'h05, q); xfer(8'h00, q);
    chk("R13 R6 wren status", q, 8'h02);
    xfer(8'h05, q); xfer(8'h00, q);
    chk("R7 R6 opcode decoded after reply", q, 8'h02);
    frame(); xfer(8'h04, q);
    read_status("R13 wrdi", 1'b0);

    frame(); xfer(8'h9F, q);
    xfer(8'h00, q); chk("R7 id byte0", q, 8'h20);
    xfer(8'h00, q); chk("R7 id byte1", q, 8'hBA);
    xfer(8'h00, q); chk("R7 id byte2", q, 8'h19);
    xfer(8'h00, q); chk("R7 ext byte0", q, 8'h10);
    xfer(8'h00, q); chk("R7 ext byte1", q, 8'hA5);
    xfer(8'h05, q); xfer(8'h00, q);
    chk("R7 idle after id", q, 8'h00);

    frame(); xfer(8'hC5, q); xfer(8'h01, q);
    read_bank("R8 bank write ignored without wel", 8'h00);
    set_bank(8'h03);
    read_bank("R8 bank write", 8'h03);
    read_status("R8 bank write keeps wel", 1'b1);
    frame(); xfer(8'h01, q); xfer(8'h00, q);
    read_status("R8 status write clears wel", 1'b0);
    m_wel = 1'b0;

    set_bank(8'h01);
    do_read("R3 R4 wrap", 8'h03, 24'hFFFFFE, 3);
    do_read("R1 fast", 8'h0B, 24'h001234, 2);
    do_read("R1 dual-out", 8'h3B, 24'h00ABCD, 2);
    do_read("R1 quad-out", 8'h6B, 24'h10FF00, 2);
    do_read("R2 dual-io", 8'hBB, 24'h456789, 2);
    do_read("R2 quad-io", 8'hEB, 24'h7FFFFF, 2);

    set_bank(8'h03);
    do_prog("R3 top bank", 24'hFFFFFE, 4);
    set_bank(8'h00);
    do_prog("R1 program", 24'h000100, 2);

    frame(); xfer(8'h04, q); m_wel = 1'b0;
    do_erase("no wel 4k", 8'h20, 24'h001000, 1'b0, 2'd0);
    frame(); xfer(8'hC7, q);
    chk("R9 chip erase blocked", {31'b0, c_ev}, 32'd0);
    set_bank(8'h02);
    do_erase("4k", 8'h20, 24'h003000, 1'b1, 2'd0);
    do_erase("32k", 8'h52, 24'h018000, 1'b1, 2'd1);
    do_erase("sector", 8'hD8, 24'hFF0000, 1'b1, 2'd2);
    frame(); xfer(8'hC7, q);
    chk("R9 chip erase valid", {31'b0, c_ev}, 32'd1);
    chk("R9 chip erase kind", c_ek, 32'd3);
    chk("R9 chip erase addr", c_ea, 32'd0);

    frame(); xfer(8'h99, q);
    read_bank("R10 unarmed reset ignored", 8'h02);
    frame(); xfer(8'h66, q); xfer(8'h05, q); xfer(8'h00, q);
    frame(); xfer(8'h99, q);
    read_bank("R10 disarmed by other opcode", 8'h02);
    frame(); xfer(8'h66, q); frame(); xfer(8'h99, q);
    read_bank("R10 armed reset clears bank", 8'h00);
    read_status("R10 armed reset clears wel", 1'b0);
    m_ear = 8'h00; m_wel = 1'b0;

    frame(); xfer(8'h03, q); xfer(8'h12, q);
    frame(); xfer(8'h05, q); xfer(8'h00, q);
    chk("R11 frame breaks collect", q, 8'h00);
    set_bank(8'h01);
    frame(); xfer(8'h03, q); xfer(8'h00, q); xfer(8'h00, q); xfer(8'h00, q);
    xfer(8'h00, q);
    frame(); xfer(8'hC8, q); xfer(8'h00, q);
    chk("R11 frame breaks stream", q, 8'h01);

    frame(); xfer(8'h77, q);
    chk("R12 unknown opcode tx", q, 8'h00);
    xfer(8'h00, q); xfer(8'h05, q); xfer(8'h00, q);
    chk("R12 decode after unknown and nop", q, 8'h02);

    for (int it = 0; it < 120; it++) begin
      case ($urandom % 3)
        0: do_read("R4 random", ops[$urandom % 6], 24'($urandom), 1 + int'($urandom % 5));
        1: do_prog("R5 random", 24'($urandom), 1 + int'($urandom % 4));
        default: set_bank({7'b0, 1'($urandom)});
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule